// File: doc/BRIEF.md
# Single-Cycle Instruction Decode and Next-PC Control

This block is the combinational control unit of a single-cycle 32-bit load/store processor that runs a ten-instruction subset: register add, subtract, AND, OR and set-less-than, add-immediate, word load, word store, branch-if-equal and an absolute jump. It splits the instruction word into its fields and decodes the opcode into the datapath steering bits. A second decode stage turns a 2-bit operation class and the function field into a 4-bit ALU code. From the current PC, the immediate, the jump target and the ALU zero flag it also forms the next PC.

The register file, ALU and memories sit outside the block. The block drives their selects and write enables. An opcode or function value outside the subset raises `bad_op`. In that case every select and enable is forced low and the PC steps by four.

Top module: `sc_decode_ctrl`

## Requirements
- R1: `imm_sext` equals instruction bits [15:0] sign-extended from bit 15, for every instruction word.
- R2: Opcode 0 is the register class. Function codes 32, 34, 36, 37 and 42 give `alu_code` 0 (add), 1 (subtract), 2 (AND), 3 (OR) and 4 (set-less-than). For these, `dst_sel_rd`=1, `rf_we`=1, `alu_b_imm`=0, `wb_from_mem`=0 and both memory enables are 0.
- R3: Opcode 35 (load) gives `alu_b_imm`=1, `wb_from_mem`=1, `rf_we`=1, `dm_re`=1, `dst_sel_rd`=0, `dm_we`=0 and `alu_code` 0.
- R4: Opcode 43 (store) gives `dm_we`=1, `alu_b_imm`=1, `rf_we`=0, `dm_re`=0 and `alu_code` 0.
- R5: Opcode 8 (add-immediate) gives `rf_we`=1, `alu_b_imm`=1, `dst_sel_rd`=0, `wb_from_mem`=0, no memory enable and `alu_code` 0.
- R6: Opcode 4 (branch-if-equal) gives `alu_code` 1 and no write enables. `pc_next` is (pc+4) + (`imm_sext` shifted left by 2) when `alu_zero` is 1, and pc+4 when it is 0, with 32-bit wrap-around.
- R7: Opcode 2 (jump) gives no write enables. `pc_next` is bits [31:28] of pc+4, then instruction bits [25:0], then two zero bits.
- R8: For every instruction other than branch and jump, `pc_next` is pc+4 (wrapping past 0xFFFFFFFC) and `alu_zero` has no effect.
- R9: Any other opcode, or opcode 0 with any other function code, sets `bad_op`=1. It drives all six select and enable outputs to 0, `alu_code` to 0 and `pc_next` to pc+4.
- R10: `dm_re` and `dm_we` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the current instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| dst_sel_rd | output | 1 | 1: write register taken from bits [15:11]; 0: from bits [20:16] |
| alu_b_imm | output | 1 | 1: ALU second operand is the extended immediate |
| wb_from_mem | output | 1 | 1: register write data comes from data memory |
| rf_we | output | 1 | Register file write enable |
| dm_re | output | 1 | Data memory read enable |
| dm_we | output | 1 | Data memory write enable |
| imm_sext | output | 32 | Sign-extended 16-bit immediate |
| alu_code | output | 4 | ALU operation code |
| pc_next | output | 32 | Address of the next instruction |
| bad_op | output | 1 | Opcode or function code outside the subset |

## Verification
The hardest cases to reach from the ports are the address-arithmetic edges. These are a branch with the most negative offset, which carries the target across the zero address; a PC whose increment crosses a 256 MB region, which changes the upper bits a jump keeps; and a PC of 0xFFFFFFFC, whose increment wraps. The stimulus table sets the PC and the offset or target fields for each of these and checks the next address against values worked out by hand. It also sets the zero flag high on non-branch and illegal words, which shows that the flag cannot redirect them.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int FN_W     = 6;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int ACODE_W  = 4;
    localparam int INSN_STEP = 4;
    localparam int REGION_W = XLEN - TGT_W - 2;

    typedef enum logic [OPC_W-1:0] {
        OP_REGCLASS = 6'd0,
        OP_JUMP     = 6'd2,
        OP_BEQ      = 6'd4,
        OP_ADDI     = 6'd8,
        OP_LOAD     = 6'd35,
        OP_STORE    = 6'd43
    } opcode_e;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 6'd32,
        FN_SUB = 6'd34,
        FN_AND = 6'd36,
        FN_OR  = 6'd37,
        FN_SLT = 6'd42
    } funct_e;

    typedef enum logic [1:0] {
        ACL_ADD   = 2'b00,
        ACL_SUB   = 2'b01,
        ACL_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [ACODE_W-1:0] {
        AC_ADD = 4'd0,
        AC_SUB = 4'd1,
        AC_AND = 4'd2,
        AC_OR  = 4'd3,
        AC_SLT = 4'd4
    } alu_code_e;

    typedef enum logic [1:0] {
        PCS_SEQ  = 2'd0,
        PCS_BR   = 2'd1,
        PCS_JUMP = 2'd2
    } pc_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0] op;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] shamt;
        logic [FN_W-1:0]  funct;
    } fields_t;

    typedef struct packed {
        logic       dst_rd;
        logic       b_imm;
        logic       from_mem;
        logic       rf_we;
        logic       dm_re;
        logic       dm_we;
        logic       is_beq;
        logic       is_jump;
        alu_class_e aclass;
        logic       legal;
    } main_ctl_t;

    localparam main_ctl_t MAIN_CTL_NONE = '{
        dst_rd: 1'b0, b_imm: 1'b0, from_mem: 1'b0, rf_we: 1'b0,
        dm_re: 1'b0, dm_we: 1'b0, is_beq: 1'b0, is_jump: 1'b0,
        aclass: ACL_ADD, legal: 1'b0
    };

    function automatic fields_t split_word(input logic [XLEN-1:0] w);
        return fields_t'(w);
    endfunction

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    output main_ctl_t        ctl
);

    always_comb begin
        ctl = MAIN_CTL_NONE;
        case (op)
            OP_REGCLASS: begin
                ctl.dst_rd = 1'b1;
                ctl.rf_we  = 1'b1;
                ctl.aclass = ACL_FUNCT;
                ctl.legal  = 1'b1;
            end
            OP_ADDI: begin
                ctl.b_imm  = 1'b1;
                ctl.rf_we  = 1'b1;
                ctl.legal  = 1'b1;
            end
            OP_LOAD: begin
                ctl.b_imm    = 1'b1;
                ctl.from_mem = 1'b1;
                ctl.rf_we    = 1'b1;
                ctl.dm_re    = 1'b1;
                ctl.legal    = 1'b1;
            end
            OP_STORE: begin
                ctl.b_imm  = 1'b1;
                ctl.dm_we  = 1'b1;
                ctl.legal  = 1'b1;
            end
            OP_BEQ: begin
                ctl.is_beq = 1'b1;
                ctl.aclass = ACL_SUB;
                ctl.legal  = 1'b1;
            end
            OP_JUMP: begin
                ctl.is_jump = 1'b1;
                ctl.legal   = 1'b1;
            end
            default: ctl = MAIN_CTL_NONE;
        endcase
    end

    always_comb begin
        AST_MEM_EXCL: assert (!(ctl.dm_re && ctl.dm_we)) else $error("both memory enables"); // R10
        AST_ILLEGAL_QUIET: assert (ctl.legal || !(ctl.rf_we || ctl.dm_we || ctl.dm_re)) else $error("illegal opcode writes"); // R9
        AST_FLOW_EXCL: assert (!(ctl.is_beq && ctl.is_jump)) else $error("branch and jump together"); // R6
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_ctrl_pkg::*;
(
    input  alu_class_e        aclass,
    input  logic [FN_W-1:0]   funct,
    output alu_code_e         code,
    output logic              funct_ok
);

    alu_code_e fn_code;
    logic      fn_known;

    always_comb begin
        fn_known = 1'b1;
        case (funct)
            FN_ADD:  fn_code = AC_ADD;
            FN_SUB:  fn_code = AC_SUB;
            FN_AND:  fn_code = AC_AND;
            FN_OR:   fn_code = AC_OR;
            FN_SLT:  fn_code = AC_SLT;
            default: begin
                fn_code  = AC_ADD;
                fn_known = 1'b0;
            end
        endcase
    end

    always_comb begin
        funct_ok = 1'b1;
        case (aclass)
            ACL_ADD:   code = AC_ADD;
            ACL_SUB:   code = AC_SUB;
            ACL_FUNCT: begin
                code     = fn_code;
                funct_ok = fn_known;
            end
            default:   code = AC_ADD;
        endcase
    end

    always_comb begin
        AST_SUB_CLASS: assert (aclass != ACL_SUB || code == AC_SUB) else $error("branch class not subtract"); // R6
        AST_BADFN_ADD: assert (funct_ok || code == AC_ADD) else $error("unknown funct code not add"); // R9
    end

endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
    import sc_ctrl_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  offs,
    input  logic [TGT_W-1:0] tgt,
    input  pc_sel_e          sel,
    output logic [XLEN-1:0]  pc_next
);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    always_comb begin
        seq_pc = pc + XLEN'(INSN_STEP);
        br_pc  = seq_pc + {offs[XLEN-3:0], 2'b00};
        jmp_pc = {seq_pc[XLEN-1 -: REGION_W], tgt, 2'b00};
        case (sel)
            PCS_BR:   pc_next = br_pc;
            PCS_JUMP: pc_next = jmp_pc;
            default:  pc_next = seq_pc;
        endcase
    end

    always_comb begin
        AST_SEQ_STEP: assert (sel != PCS_SEQ || (pc_next - pc) == XLEN'(INSN_STEP)) else $error("sequential step wrong"); // R8
        AST_JMP_REGION: assert (sel != PCS_JUMP || (pc_next[1:0] == 2'b00 &&
            pc_next[XLEN-1 -: REGION_W] == seq_pc[XLEN-1 -: REGION_W])) else $error("jump leaves region"); // R7
        AST_BR_ALIGN: assert (sel != PCS_BR || pc_next[1:0] == pc[1:0]) else $error("branch misaligned"); // R6
    end

endmodule

// File: rtl/sc_decode_ctrl.sv
module sc_decode_ctrl
    import sc_ctrl_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] pc,
    input  logic        alu_zero,
    output logic        dst_sel_rd,
    output logic        alu_b_imm,
    output logic        wb_from_mem,
    output logic        rf_we,
    output logic        dm_re,
    output logic        dm_we,
    output logic [31:0] imm_sext,
    output logic [3:0]  alu_code,
    output logic [31:0] pc_next,
    output logic        bad_op
);

    fields_t   fld;
    main_ctl_t mctl;
    alu_code_e acode;
    logic      fn_ok;
    pc_sel_e   psel;

    always_comb begin
        fld      = split_word(instr);
        imm_sext = widen_imm(instr[IMM_W-1:0]);
    end

    sc_main_dec u_main (
        .op  (fld.op),
        .ctl (mctl)
    );

    sc_alu_dec u_alu (
        .aclass   (mctl.aclass),
        .funct    (fld.funct),
        .code     (acode),
        .funct_ok (fn_ok)
    );

    always_comb begin
        bad_op = !mctl.legal || !fn_ok;
        if (bad_op)
            psel = PCS_SEQ;
        else if (mctl.is_jump)
            psel = PCS_JUMP;
        else if (mctl.is_beq && alu_zero)
            psel = PCS_BR;
        else
            psel = PCS_SEQ;
    end

    sc_next_pc u_npc (
        .pc      (pc),
        .offs    (imm_sext),
        .tgt     (instr[TGT_W-1:0]),
        .sel     (psel),
        .pc_next (pc_next)
    );

    always_comb begin
        dst_sel_rd  = mctl.dst_rd   && !bad_op;
        alu_b_imm   = mctl.b_imm    && !bad_op;
        wb_from_mem = mctl.from_mem && !bad_op;
        rf_we       = mctl.rf_we    && !bad_op;
        dm_re       = mctl.dm_re    && !bad_op;
        dm_we       = mctl.dm_we    && !bad_op;
        alu_code    = bad_op ? AC_ADD : acode;
    end

    always_comb begin
        AST_BAD_NO_WRITE: assert (!bad_op || !(rf_we || dm_we || dm_re)) else $error("illegal word enables write"); // R9
        AST_WB_NEEDS_READ: assert (!wb_from_mem || (dm_re && rf_we)) else $error("memory writeback without read"); // R3
        AST_DST_RD_REG: assert (!dst_sel_rd || (rf_we && !alu_b_imm)) else $error("rd destination outside register class"); // R2
    end

endmodule

// File: tb/sim_sc_decode_ctrl.sv
`timescale 1ns/1ps
module sim_sc_decode_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0] instr, pc;
    logic        alu_zero;
    logic        dst_sel_rd, alu_b_imm, wb_from_mem, rf_we, dm_re, dm_we, bad_op;
    logic [31:0] imm_sext, pc_next;
    logic [3:0]  alu_code;

    int checks = 0;
    int errors = 0;

    sc_decode_ctrl u0 (
        .instr(instr), .pc(pc), .alu_zero(alu_zero),
        .dst_sel_rd(dst_sel_rd), .alu_b_imm(alu_b_imm), .wb_from_mem(wb_from_mem),
        .rf_we(rf_we), .dm_re(dm_re), .dm_we(dm_we), .imm_sext(imm_sext),
        .alu_code(alu_code), .pc_next(pc_next), .bad_op(bad_op)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Row: {instr, pc, zero, ctl{dst,bimm,mem,rfwe,dmre,dmwe,bad}, alu, pc_next}
    localparam int NV = 16;
    localparam logic [107:0] TBL [0:NV-1] = '{
        {enc_r(5'd10, 5'd30, 5'd4, 6'd32), 32'h0000_0100, 1'b0, 7'b1001000, 4'd0, 32'h0000_0104}, // R2 add
        {enc_r(5'd1, 5'd2, 5'd3, 6'd34),   32'h0000_0200, 1'b1, 7'b1001000, 4'd1, 32'h0000_0204}, // R2 sub, R8 zero ignored
        {enc_r(5'd1, 5'd2, 5'd3, 6'd36),   32'hFFFF_FFFC, 1'b0, 7'b1001000, 4'd2, 32'h0000_0000}, // R2 and, R8 wrap
        {enc_r(5'd7, 5'd8, 5'd9, 6'd37),   32'h0000_0010, 1'b0, 7'b1001000, 4'd3, 32'h0000_0014}, // R2 or
        {enc_r(5'd7, 5'd8, 5'd9, 6'd42),   32'h0000_0020, 1'b0, 7'b1001000, 4'd4, 32'h0000_0024}, // R2 slt
        {enc_i(6'd35, 5'd3, 5'd2, 16'h000A), 32'h0000_0040, 1'b1, 7'b0111100, 4'd0, 32'h0000_0044}, // R3 load
        {enc_i(6'd43, 5'd3, 5'd2, 16'hFFF0), 32'h0000_0080, 1'b0, 7'b0100010, 4'd0, 32'h0000_0084}, // R4 store
        {enc_i(6'd8, 5'd10, 5'd4, 16'h000F), 32'h0000_0090, 1'b1, 7'b0101000, 4'd0, 32'h0000_0094}, // R5 addi
        {enc_i(6'd4, 5'd1, 5'd2, 16'h0003), 32'h0000_1000, 1'b1, 7'b0000000, 4'd1, 32'h0000_1010}, // R6 taken
        {enc_i(6'd4, 5'd1, 5'd2, 16'h0003), 32'h0000_1000, 1'b0, 7'b0000000, 4'd1, 32'h0000_1004}, // R6 not taken
        {enc_i(6'd4, 5'd1, 5'd2, 16'hFFFE), 32'h0000_2000, 1'b1, 7'b0000000, 4'd1, 32'h0000_1FFC}, // R6 backward
        {enc_i(6'd4, 5'd1, 5'd2, 16'h8000), 32'h0001_0000, 1'b1, 7'b0000000, 4'd1, 32'hFFFF_0004}, // R6 most negative
        {{6'd2, 26'h1234567},               32'hA000_0000, 1'b1, 7'b0000000, 4'd0, 32'hA48D_159C}, // R7 jump
        {{6'd2, 26'h1234567},               32'hAFFF_FFFC, 1'b0, 7'b0000000, 4'd0, 32'hB48D_159C}, // R7 region cross
        {enc_i(6'd63, 5'd1, 5'd2, 16'h0004), 32'h0000_0300, 1'b1, 7'b0000001, 4'd0, 32'h0000_0304}, // R9 bad opcode
        {enc_r(5'd1, 5'd2, 5'd3, 6'd33),   32'h0000_0400, 1'b1, 7'b0000001, 4'd0, 32'h0000_0404}  // R9 bad funct
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ctl_bits();
        return {dst_sel_rd, alu_b_imm, wb_from_mem, rf_we, dm_re, dm_we, bad_op};
    endfunction

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        instr = 32'd0; pc = 32'h0000_0000; alu_zero = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset-time word of zero: funct 0 is outside the subset
        chk("R9 reset ctl", {25'd0, ctl_bits()}, 32'h0000_0001);
        chk("R8 reset pc_next", pc_next, 32'h0000_0004);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr    = TBL[i][107:76];
            pc       = TBL[i][75:44];
            alu_zero = TBL[i][43];
            @(posedge clk);
            #1;
            chk($sformatf("vec%0d ctl R2-table", i), {25'd0, ctl_bits()}, {25'd0, TBL[i][42:36]});
            chk($sformatf("vec%0d alu_code", i), {28'd0, alu_code}, {28'd0, TBL[i][35:32]});
            chk($sformatf("vec%0d pc_next", i), pc_next, TBL[i][31:0]);
            chk($sformatf("vec%0d R10 mem excl", i), {31'd0, dm_re & dm_we}, 32'd0);
        end

        // R1: sign extension of negative and positive immediates
        @(negedge clk);
        instr = enc_i(6'd43, 5'd3, 5'd2, 16'hFFF0); #2;
        chk("R1 negative imm", imm_sext, 32'hFFFF_FFF0);
        instr = enc_i(6'd8, 5'd3, 5'd2, 16'h7FFF); #2;
        chk("R1 positive imm", imm_sext, 32'h0000_7FFF);
        instr = enc_r(5'd1, 5'd2, 5'd3, 6'd42); #2;
        chk("R1 register word imm", imm_sext, 32'h0000_182A);

        // R8: zero flag cannot redirect a load or an add-immediate
        instr = enc_i(6'd35, 5'd0, 5'd1, 16'h0040); pc = 32'h0000_5000; alu_zero = 1'b1; #2;
        chk("R8 load with zero", pc_next, 32'h0000_5004);
        instr = enc_i(6'd8, 5'd0, 5'd1, 16'hFFFF); alu_zero = 1'b1; #2;
        chk("R8 addi with zero", pc_next, 32'h0000_5004);
        // R9: bad opcode that resembles a branch field layout ignores zero
        instr = enc_i(6'd5, 5'd1, 5'd1, 16'h0010); alu_zero = 1'b1; #2;
        chk("R9 opcode 5 flag", {31'd0, bad_op}, 32'd1);
        chk("R9 opcode 5 pc", pc_next, 32'h0000_5004);
        // R7: jump ignores zero flag and keeps region bits
        instr = {6'd2, 26'h3FFFFFF}; pc = 32'h1234_5678; alu_zero = 1'b0; #2;
        chk("R7 jump max target", pc_next, 32'h1FFF_FFFC);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule